// File: doc/BRIEF.md
# Burst-of-Two Quad-Rate SRAM Model

A synthesizable behavioural model of a static memory with separate read and write data ports, one shared address bus and a fixed burst of two words per command. The model runs on one beat clock. Every rising edge of that clock stands for one edge of the interface clock pair. The input `ph_true` is high when the coming edge is the rise of the true clock and low when it is the rise of the complemented clock. A host drives `ph_true` so that it alternates on every beat.

Read and write commands are both sampled on true-clock edges, so one of each can be issued in the same cycle. The address bus carries the read address on true-clock edges and the write address on complemented-clock edges. Read data returns as two words on consecutive beats after a fixed pipeline delay. `rvalid` stands in for the driven (not high-impedance) state of the output pads. Stores are masked in 9-bit lanes.

Top module: `qdr_b2_sram`

## Requirements
- R1: After reset, `rvalid` is low and `rdata` is zero until a read command produces data.
- R2: A read is taken when `rd_sel_n` is low on a beat with `ph_true` high. Call that beat edge t. The first word is presented after edge t+3 and the second after edge t+4. `rvalid` is high for exactly those two beats.
- R3: The first word of a burst comes from the base address. The second comes from the base address with bit 0 inverted and all upper bits kept.
- R4: Read commands on consecutive true-clock edges give `rvalid` high on every beat, with no gap, until the last burst ends.
- R5: When no read follows, `rvalid` goes low and `rdata` returns to zero on the edge right after the second word of the last burst.
- R6: A write is taken when `wr_sel_n` is low on a true-clock edge t. The write base address is taken from `addr` at edge t+1. The first data word is taken at edge t+2 (stored at the base) and the second at edge t+3 (stored at base with bit 0 inverted). Write commands may follow one another on every true-clock edge.
- R7: `wbe_n` is sampled with each data word. Bit l, when low, stores bits [9l+8:9l] of `wdata`. When high, it leaves those stored bits unchanged.
- R8: A read and a write may be issued on the same true-clock edge. A read returns the effect of every write commanded on the same or an earlier true-clock edge, merged lane by lane. This includes a second write word that is still being stored when the read word is taken. A write commanded on a later edge does not affect it.
- R9: `rd_sel_n` and `wr_sel_n` are ignored on beats with `ph_true` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock; each rising edge is one interface clock edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| ph_true | input | 1 | High when the coming edge is a true-clock rise |
| rd_sel_n | input | 1 | Active-low read command, sampled on true-clock edges |
| wr_sel_n | input | 1 | Active-low write command, sampled on true-clock edges |
| addr | input | AW | Shared address: read base on true edges, write base on complemented edges |
| wdata | input | DW | Write data word, one per beat during a write burst |
| wbe_n | input | DW/9 | Active-low lane write enables, one per 9-bit lane |
| rdata | output | DW | Read data word, zero while not valid |
| rvalid | output | 1 | High while `rdata` is driven |

## Verification
Reading and storing can land on the same beat edge. The critical case is when the first read word is fetched on the complemented-clock edge that stores the second word of a write issued together with the read. The bench provokes this by issuing a read of base 4 and a write of base 5 on the same true edge, with only one lane enabled on the write's second word. It expects the fetched word to carry the new lane and the old one side by side. A second write, commanded one cycle later to the same pair of locations, must stay invisible to that burst and visible to the next read.

// File: rtl/qdr_b2_pkg.sv
package qdr_b2_pkg;
   // width of one byte-write lane
   localparam int unsigned LANE_W = 9;
   // edge type carried by the phase input
   typedef enum logic {EDGE_COMP = 1'b0, EDGE_TRUE = 1'b1} edge_e;
endpackage

// File: rtl/qdr_b2_array.sv
module qdr_b2_array
   import qdr_b2_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int DW    = 18,
   localparam int AW   = $clog2(DEPTH),
   localparam int LN   = DW / LANE_W
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [LN-1:0] wbe_n,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   // one storage column per lane so masking is a per-column enable
   for (genvar g = 0; g < LN; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      always_ff @(posedge clk) begin
         if (we && !wbe_n[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
      assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
   end
endmodule

// File: rtl/qdr_b2_wr_path.sv
module qdr_b2_wr_path
   import qdr_b2_pkg::*;
#(
   parameter int AW = 10,
   parameter int DW = 18,
   localparam int LN = DW / LANE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ph_true,
   input  logic          wr_sel_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [LN-1:0] wbe_n,
   output logic          cm_en,
   output logic          cm_tail,
   output logic [AW-1:0] cm_addr,
   output logic [DW-1:0] cm_data,
   output logic [LN-1:0] cm_be_n
);
   logic          cmd_q;    // write command seen on the last true edge
   logic          act_q;    // burst has its base address, data beats running
   logic [AW-1:0] base_q;
   edge_e         edge_kind;

   assign edge_kind = edge_e'(ph_true);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= 1'b0;
         act_q  <= 1'b0;
         base_q <= '0;
      end else if (edge_kind == EDGE_TRUE) begin
         cmd_q <= !wr_sel_n;
      end else begin
         act_q <= cmd_q;
         if (cmd_q) base_q <= addr;
      end
   end

   // word 0 lands on the true edge, word 1 on the complemented edge
   assign cm_en   = act_q;
   assign cm_tail = act_q && (edge_kind == EDGE_COMP);
   assign cm_addr = (edge_kind == EDGE_TRUE) ? base_q : {base_q[AW-1:1], ~base_q[0]};
   assign cm_data = wdata;
   assign cm_be_n = wbe_n;
endmodule

// File: rtl/qdr_b2_rd_path.sv
module qdr_b2_rd_path
   import qdr_b2_pkg::*;
#(
   parameter int AW = 10,
   parameter int DW = 18,
   localparam int LN = DW / LANE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ph_true,
   input  logic          rd_sel_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] arr_q,
   input  logic          cm_tail,
   input  logic [AW-1:0] cm_addr,
   input  logic [DW-1:0] cm_data,
   input  logic [LN-1:0] cm_be_n,
   output logic [AW-1:0] arr_addr,
   output logic [DW-1:0] rdata,
   output logic          rvalid
);
   logic          req_v_q, out_v_q;
   logic [AW-1:0] req_a_q, out_a_q;
   logic [DW-1:0] word;
   logic          hit;
   edge_e         edge_kind;

   assign edge_kind = edge_e'(ph_true);
   assign arr_addr  = (edge_kind == EDGE_TRUE) ? {out_a_q[AW-1:1], ~out_a_q[0]} : out_a_q;

   // the tail word of a burst being stored this edge is not in the array yet
   assign hit = cm_tail && (cm_addr == arr_addr);

   for (genvar g = 0; g < LN; g++) begin : g_merge
      assign word[g*LANE_W +: LANE_W] = (hit && !cm_be_n[g]) ? cm_data[g*LANE_W +: LANE_W]
                                                            : arr_q[g*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_v_q <= 1'b0;
         req_a_q <= '0;
         out_v_q <= 1'b0;
         out_a_q <= '0;
         rvalid  <= 1'b0;
         rdata   <= '0;
      end else begin
         rvalid <= out_v_q;
         rdata  <= out_v_q ? word : '0;
         if (edge_kind == EDGE_TRUE) begin
            req_v_q <= !rd_sel_n;
            if (!rd_sel_n) req_a_q <= addr;
            out_v_q <= req_v_q;
            out_a_q <= req_a_q;
         end
      end
   end
endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram
   import qdr_b2_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int DW    = 18,
   localparam int AW   = $clog2(DEPTH),
   localparam int LN   = DW / LANE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ph_true,
   input  logic          rd_sel_n,
   input  logic          wr_sel_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [LN-1:0] wbe_n,
   output logic [DW-1:0] rdata,
   output logic          rvalid
);
   if ((DW % LANE_W) != 0 || DW < LANE_W) begin : g_bad_width
      $error("qdr_b2_sram: DW must be a positive multiple of the lane width");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("qdr_b2_sram: DEPTH must be a power of two of at least 2");
   end

   logic          cm_en, cm_tail;
   logic [AW-1:0] cm_addr, arr_addr;
   logic [DW-1:0] cm_data, arr_q;
   logic [LN-1:0] cm_be_n;

   qdr_b2_wr_path #(.AW(AW), .DW(DW)) u_wr (
      .clk(clk), .rst_n(rst_n), .ph_true(ph_true), .wr_sel_n(wr_sel_n),
      .addr(addr), .wdata(wdata), .wbe_n(wbe_n),
      .cm_en(cm_en), .cm_tail(cm_tail), .cm_addr(cm_addr),
      .cm_data(cm_data), .cm_be_n(cm_be_n)
   );

   qdr_b2_array #(.DEPTH(DEPTH), .DW(DW)) u_arr (
      .clk(clk), .we(cm_en), .waddr(cm_addr), .wdata(cm_data),
      .wbe_n(cm_be_n), .raddr(arr_addr), .rdata(arr_q)
   );

   qdr_b2_rd_path #(.AW(AW), .DW(DW)) u_rd (
      .clk(clk), .rst_n(rst_n), .ph_true(ph_true), .rd_sel_n(rd_sel_n),
      .addr(addr), .arr_q(arr_q), .cm_tail(cm_tail), .cm_addr(cm_addr),
      .cm_data(cm_data), .cm_be_n(cm_be_n), .arr_addr(arr_addr),
      .rdata(rdata), .rvalid(rvalid)
   );
endmodule

// File: rtl/qdr_b2_sram_chk.sv
module qdr_b2_sram_chk (
   input logic clk,
   input logic rst_n,
   input logic ph_true,
   input logic rd_sel_n,
   input logic rvalid
);
   // read select as seen on the previous true edge
   logic prev_idle_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_idle_q <= 1'b1;
      else if (ph_true) prev_idle_q <= rd_sel_n;
   end

   assert_rise_after_comp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rvalid) |-> ph_true);

   assert_two_beats_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rvalid) |=> rvalid);

   assert_first_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_true && !rd_sel_n) |-> ##4 rvalid);

   assert_second_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_true && !rd_sel_n) |-> ##5 rvalid);

   assert_idle_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_true && rd_sel_n && prev_idle_q) |-> ##4 !rvalid);
endmodule

bind qdr_b2_sram qdr_b2_sram_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ph_true(ph_true), .rd_sel_n(rd_sel_n), .rvalid(rvalid)
);

// File: tb/qdr_b2_sram_bench.sv
module qdr_b2_sram_bench;
   localparam int DEPTH = 1024;
   localparam int DW    = 18;
   localparam int AW    = $clog2(DEPTH);
   localparam int LN    = DW / 9;

   logic          clk = 1'b0;
   logic          rst_n, ph_true, rd_sel_n, wr_sel_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata, rdata;
   logic [LN-1:0] wbe_n;
   logic          rvalid;

   int checks = 0;
   int failures = 0;
   int bt = 0;
   string cur_req = "R1";

   // expectation model driven by the requirement text
   logic [DW-1:0] ref_mem [DEPTH];
   logic          rec_v  [8];
   logic [AW-1:0] rec_a  [8];
   logic [DW-1:0] rec_d1 [8];
   logic          m_wcmd = 1'b0, m_wact = 1'b0;
   logic [AW-1:0] m_wa = '0;

   always #10 clk = ~clk;

   qdr_b2_sram #(.DEPTH(DEPTH), .DW(DW)) u_qdr_b2_sram (
      .clk(clk), .rst_n(rst_n), .ph_true(ph_true), .rd_sel_n(rd_sel_n),
      .wr_sel_n(wr_sel_n), .addr(addr), .wdata(wdata), .wbe_n(wbe_n),
      .rdata(rdata), .rvalid(rvalid)
   );

   function automatic logic [AW-1:0] partner(input logic [AW-1:0] a);
      return {a[AW-1:1], ~a[0]};
   endfunction

   task automatic fail(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at beat %0d", req, what, act, exp, bt);
   endtask

   task automatic apply(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LN-1:0] be);
      for (int l = 0; l < LN; l++)
         if (!be[l]) ref_mem[a][l*9 +: 9] = d[l*9 +: 9];
   endtask

   // outputs after edge bt-1, sampled at the falling edge before edge bt
   task automatic check_out();
      int e;
      logic ev;
      logic [DW-1:0] ed;
      e = bt - 1;
      ev = 1'b0;
      ed = '0;
      if (e >= 3 && e[0] == 1'b1 && rec_v[(e-3)%8]) begin
         ev = 1'b1;
         ed = ref_mem[rec_a[(e-3)%8]];
         rec_d1[(e-3)%8] = ref_mem[partner(rec_a[(e-3)%8])];
      end else if (e >= 4 && e[0] == 1'b0 && rec_v[(e-4)%8]) begin
         ev = 1'b1;
         ed = rec_d1[(e-4)%8];
      end
      if (e >= 0) begin
         checks++;
         if (rvalid !== ev) fail(cur_req, "rvalid", DW'(rvalid), DW'(ev));
         else if (rdata !== ed) fail(cur_req, "rdata", rdata, ed);
      end
   endtask

   task automatic step(input logic rn, input logic wn, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [LN-1:0] be);
      @(negedge clk);
      check_out();
      ph_true = (bt % 2 == 0);
      rd_sel_n = rn; wr_sel_n = wn; addr = a; wdata = d; wbe_n = be;
      if (bt % 2 == 0) begin
         if (m_wact) apply(m_wa, d, be);
         m_wcmd = !wn;
         rec_v[bt%8] = !rn;
         rec_a[bt%8] = a;
      end else begin
         if (m_wact) apply(partner(m_wa), d, be);
         m_wact = m_wcmd;
         if (m_wcmd) m_wa = a;
      end
      @(posedge clk);
      bt++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b1, 1'b1, '0, '0, '1);
   endtask

   task automatic align_true();
      if (bt % 2 != 0) idle(1);
   endtask

   task automatic wr_burst(input logic [AW-1:0] base, input logic [DW-1:0] d0, input logic [LN-1:0] be0,
                           input logic [DW-1:0] d1, input logic [LN-1:0] be1);
      align_true();
      step(1'b1, 1'b0, '0, '0, '1);
      step(1'b1, 1'b1, base, '0, '1);
      step(1'b1, 1'b1, '0, d0, be0);
      step(1'b1, 1'b1, '0, d1, be1);
   endtask

   task automatic rd_burst(input logic [AW-1:0] base);
      align_true();
      step(1'b0, 1'b1, base, '0, '1);
      idle(6);
   endtask

   task automatic t_reset();
      cur_req = "R1";
      @(negedge clk);
      checks++;
      if (rvalid !== 1'b0) fail("R1", "rvalid after reset", DW'(rvalid), '0);
      checks++;
      if (rdata !== '0) fail("R1", "rdata after reset", rdata, '0);
      idle(6);
   endtask

   task automatic t_basic();
      cur_req = "R6";
      wr_burst(10'd10, 18'h1234A, '0, 18'h0BEEF, '0);
      idle(2);
      cur_req = "R2";
      rd_burst(10'd10);
      cur_req = "R3";
      rd_burst(10'd11);
      wr_burst(10'd13, 18'h2AAAA, '0, 18'h15555, '0);
      idle(2);
      rd_burst(10'd12);
   endtask

   task automatic t_lanes();
      cur_req = "R7";
      wr_burst(10'd20, 18'h3FFFF, '0, 18'h3FFFF, '0);
      wr_burst(10'd20, 18'h00000, 2'b10, 18'h00000, 2'b01);
      idle(2);
      rd_burst(10'd20);
      wr_burst(10'd20, 18'h12345, 2'b11, 18'h12345, 2'b11);
      idle(2);
      rd_burst(10'd21);
   endtask

   task automatic t_stream();
      cur_req = "R6";
      align_true();
      step(1'b1, 1'b0, '0, '0, '1);
      step(1'b1, 1'b1, 10'd40, '0, '1);
      step(1'b1, 1'b0, '0, 18'h00040, '0);
      step(1'b1, 1'b1, 10'd42, 18'h00041, '0);
      step(1'b1, 1'b0, '0, 18'h00042, '0);
      step(1'b1, 1'b1, 10'd44, 18'h00043, '0);
      step(1'b1, 1'b1, '0, 18'h00044, '0);
      step(1'b1, 1'b1, '0, 18'h00045, '0);
      idle(2);
      cur_req = "R4";
      step(1'b0, 1'b1, 10'd40, '0, '1);
      step(1'b1, 1'b1, '0, '0, '1);
      step(1'b0, 1'b1, 10'd43, '0, '1);
      step(1'b1, 1'b1, '0, '0, '1);
      step(1'b0, 1'b1, 10'd44, '0, '1);
      step(1'b1, 1'b1, '0, '0, '1);
      step(1'b1, 1'b1, '0, '0, '1);
      cur_req = "R5";
      idle(6);
   endtask

   task automatic t_same_edge();
      cur_req = "R8";
      wr_burst(10'd4, 18'h0AAAA, '0, 18'h3C3C3, '0);
      idle(2);
      step(1'b0, 1'b0, 10'd4, '0, '1);
      step(1'b1, 1'b1, 10'd5, '0, '1);
      step(1'b1, 1'b0, '0, 18'h11111, '0);
      step(1'b1, 1'b1, 10'd5, 18'h2F0F0, 2'b10);
      step(1'b1, 1'b1, '0, 18'h01234, '0);
      step(1'b1, 1'b1, '0, 18'h04321, '0);
      idle(4);
      rd_burst(10'd4);
   endtask

   task automatic t_ignore();
      cur_req = "R9";
      wr_burst(10'd30, 18'h1F00F, '0, 18'h20FF0, '0);
      idle(2);
      align_true();
      idle(1);
      step(1'b0, 1'b0, 10'd30, '0, '1);
      step(1'b1, 1'b1, 10'd30, 18'h00777, '0);
      step(1'b1, 1'b1, 10'd30, 18'h00777, '0);
      step(1'b1, 1'b1, '0, 18'h00777, '0);
      idle(6);
      rd_burst(10'd30);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) begin
         rec_v[i] = 1'b0; rec_a[i] = '0; rec_d1[i] = '0;
      end
      rst_n = 1'b0; ph_true = 1'b0; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
      addr = '0; wdata = '0; wbe_n = '1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_lanes();
      t_stream();
      t_same_edge();
      t_ignore();
      idle(2);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule